// File: doc/BRIEF.md
# Receive Line Idle Timeout Detector

This block watches the receive side of a serial port and reports when the line has gone quiet for too long after a character. Time is measured in bit periods: the baud generator supplies a one-cycle tick per bit period, and the block counts those ticks. Counting begins when the receiver reports a finished character. A detected start bit stops and clears the count. A later finished character starts the count again from zero.

When the count reaches the programmed limit, a sticky timeout flag is set. The flag stays set until software pulses a clear strobe. An interrupt request follows the flag whenever the interrupt enable is on. The limit may be changed at any time. A new limit at or below the running count sets the flag on the next clock edge.

The receiver, the baud generator and the register bus that holds the limit and enables are outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_flag` and `timeout_irq` are 0 and the counter is idle (not counting).
- R2: A `char_done` pulse with `enable` high arms the counter at zero. Each later `bit_tick` adds one to the count. With limit L, `timeout_flag` becomes 1 on the clock edge after the L-th tick has been counted. For L = 0, it becomes 1 on the edge after the arming edge. No tick count below L sets it.
- R3: A `start_seen` pulse clears the count and disarms the counter. If `start_seen` and `char_done` arrive in the same cycle, `start_seen` wins and the counter stays disarmed.
- R4: Ticks never advance the count while the counter is disarmed. This covers the time after reset, after enable, after a start bit and after a timeout, until a character completes.
- R5: A new `char_done` while the counter is armed restarts the count from zero.
- R6: `limit` is compared against the running count on every cycle while armed. A value written at or below the current count sets `timeout_flag` on the next clock edge. A value above it does not.
- R7: `timeout_flag` stays 1 until a `flag_clr` pulse clears it on the next edge. If a new timeout occurs in the same cycle as `flag_clr`, the flag stays 1.
- R8: A timeout disarms the counter. After the flag is cleared, ticks do not set it again until another character completes.
- R9: While `enable` is 0, the count is held at zero and disarmed. A flag that is already set keeps its value.
- R10: `timeout_irq` is 1 exactly when `timeout_flag` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timeout function on |
| irq_en | input | 1 | Interrupt enable for the timeout flag |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_done | input | 1 | One-cycle pulse: a character was received |
| start_seen | input | 1 | One-cycle pulse: a start bit was detected |
| limit | input | CNT_W | Timeout in bit periods |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| timeout_flag | output | 1 | Sticky timeout flag |
| timeout_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `char_done`, `start_seen` and `bit_tick` are synchronous one-cycle pulses. They also assume that `limit` changes only on clock edges and is far below the largest count, so the count never saturates while a check is active. The stimulus drives every input on the falling edge. It holds each event high for exactly one cycle and keeps limits below 25 bit periods, so these assumptions always hold. Corner cases (same-cycle start and character, clear racing a new timeout, limit rewrites) are built from the same single-cycle pulses.

// File: rtl/rto_pkg.sv
package rto_pkg;

    localparam int RTO_CNT_W = 24;

    // Per-cycle events that steer the bit-period counter
    typedef struct packed {
        logic enable;
        logic start_seen;
        logic char_done;
        logic bit_tick;
    } rto_ev_t;

endpackage

// File: rtl/rto_counter.sv
module rto_counter
    import rto_pkg::*;
#(
    parameter int CNT_W = RTO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rto_ev_t          ev,
    input  logic             hit,
    output logic             armed,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ev.enable) begin
            st_d = '0;
        end else if (ev.start_seen) begin
            st_d = '0;
        end else if (ev.char_done) begin
            st_d.armed = 1'b1;
            st_d.count = '0;
        end else if (hit) begin
            st_d.armed = 1'b0;
        end else if (st_q.armed && ev.bit_tick && st_q.count != CNT_MAX) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
    assign count = st_q.count;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.enable && ev.start_seen) |=> (count == '0 && !armed)); // R3

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.enable |=> (count == '0 && !armed)); // R9

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.enable && armed && ev.bit_tick && !ev.start_seen && !ev.char_done
         && !hit && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R2

    AST_NO_COUNT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !ev.char_done) |=> (count == '0 || $stable(count))); // R4

endmodule

// File: rtl/rto_compare.sv
module rto_compare #(
    parameter int CNT_W = 24
) (
    input  logic             enable,
    input  logic             start_seen,
    input  logic             armed,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    // Continuous compare: a lowered limit fires as soon as it is seen
    always_comb begin
        hit = enable && armed && !start_seen && (count >= limit);
    end

endmodule

// File: rtl/rto_flag.sv
module rto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_clr) st_d.flag = 1'b0;
        if (hit)      st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R7

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R7

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rto_pkg::*;
#(
    parameter int CNT_W = RTO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             irq_en,
    input  logic             bit_tick,
    input  logic             char_done,
    input  logic             start_seen,
    input  logic [CNT_W-1:0] limit,
    input  logic             flag_clr,
    output logic             timeout_flag,
    output logic             timeout_irq
);

    rto_ev_t          ev;
    logic             hit;
    logic             armed;
    logic [CNT_W-1:0] count;

    always_comb begin
        ev.enable     = enable;
        ev.start_seen = start_seen;
        ev.char_done  = char_done;
        ev.bit_tick   = bit_tick;
    end

    rto_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .hit   (hit),
        .armed (armed),
        .count (count)
    );

    rto_compare #(.CNT_W(CNT_W)) i_compare (
        .enable     (enable),
        .start_seen (start_seen),
        .armed      (armed),
        .count      (count),
        .limit      (limit),
        .hit        (hit)
    );

    rto_flag i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .flag     (timeout_flag),
        .irq      (timeout_irq)
    );

    AST_STOP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(timeout_flag) && !$past(char_done)) |-> !armed); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> (timeout_flag && irq_en)); // R10

endmodule

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         irq_en = 1'b0;
    logic         bit_tick = 1'b0;
    logic         char_done = 1'b0;
    logic         start_seen = 1'b0;
    logic [W-1:0] limit = '0;
    logic         flag_clr = 1'b0;
    logic         timeout_flag;
    logic         timeout_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_idle_timeout #(.CNT_W(W)) i_rx_idle_timeout (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .irq_en       (irq_en),
        .bit_tick     (bit_tick),
        .char_done    (char_done),
        .start_seen   (start_seen),
        .limit        (limit),
        .flag_clr     (flag_clr),
        .timeout_flag (timeout_flag),
        .timeout_irq  (timeout_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_char();
        char_done = 1'b1; @(negedge clk); char_done = 1'b0;
    endtask

    task automatic pulse_start();
        start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk("R1 flag after reset", timeout_flag, 1'b0);
        chk("R1 irq after reset", timeout_irq, 1'b0);
        rst_n = 1'b1;
        enable = 1'b1;
        limit = 2;
        idle(1);
        // R4: no character yet, ticks must not count
        ticks(10, 0); idle(2);
        chk("R4 no count before char", timeout_flag, 1'b0);

        // R2: sweep limit and tick spacing
        for (int l = 0; l < 8; l++) begin
            for (int g = 0; g < 3; g++) begin
                limit = W'(l);
                pulse_char();
                if (l > 0) begin
                    ticks(l - 1, g); idle(3);
                    chk("R2 below limit", timeout_flag, 1'b0);
                    ticks(1, 0);
                end
                idle(1);
                chk("R2 at limit", timeout_flag, 1'b1);
                pulse_clr(); idle(1);
                chk("R7 clear", timeout_flag, 1'b0);
            end
        end

        // R8: after timeout and clear, ticks do not refire
        ticks(12, 1); idle(2);
        chk("R8 no refire after clear", timeout_flag, 1'b0);

        // R3: start bit clears and disarms
        limit = 4;
        pulse_char(); ticks(3, 0); pulse_start(); ticks(10, 0); idle(2);
        chk("R3 start disarms", timeout_flag, 1'b0);
        char_done = 1'b1; start_seen = 1'b1; @(negedge clk);
        char_done = 1'b0; start_seen = 1'b0;
        ticks(10, 0); idle(2);
        chk("R3 start wins over char", timeout_flag, 1'b0);
        pulse_char(); ticks(3, 0); idle(2);
        chk("R3 count restarted", timeout_flag, 1'b0);
        ticks(1, 0); idle(1);
        chk("R3 fires after full count", timeout_flag, 1'b1);
        pulse_clr();

        // R5: a second char restarts the count
        pulse_char(); ticks(3, 0); pulse_char(); ticks(3, 0); idle(2);
        chk("R5 restart on char", timeout_flag, 1'b0);
        ticks(1, 0); idle(1);
        chk("R5 fires after restart", timeout_flag, 1'b1);
        pulse_clr();

        // R6: limit rewrite
        limit = 20;
        pulse_char(); ticks(5, 0); idle(2);
        chk("R6 high limit", timeout_flag, 1'b0);
        limit = 6; idle(2);
        chk("R6 limit above count", timeout_flag, 1'b0);
        limit = 5; idle(1);
        chk("R6 limit equal count", timeout_flag, 1'b1);
        pulse_clr();
        limit = 20;
        pulse_char(); ticks(5, 0);
        limit = 3; idle(1);
        chk("R6 limit below count", timeout_flag, 1'b1);

        // R7: sticky, and set wins over clear
        idle(10);
        chk("R7 sticky", timeout_flag, 1'b1);
        limit = 0;
        pulse_char();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R7 set wins over clear", timeout_flag, 1'b1);
        pulse_clr();
        chk("R7 plain clear", timeout_flag, 1'b0);

        // R10: interrupt gating
        pulse_char(); idle(1);
        chk("R10 irq off", timeout_irq, 1'b0);
        irq_en = 1'b1; idle(1);
        chk("R10 irq on", timeout_irq, 1'b1);
        pulse_clr();
        chk("R10 irq low with flag low", timeout_irq, 1'b0);

        // R9: disable clears counter, keeps flag
        limit = 4;
        pulse_char(); ticks(2, 0);
        enable = 1'b0; idle(1); ticks(5, 0); idle(2);
        chk("R9 off no timeout", timeout_flag, 1'b0);
        enable = 1'b1; ticks(10, 0); idle(2);
        chk("R9 re-enable stays idle", timeout_flag, 1'b0);
        limit = 0;
        pulse_char(); idle(1);
        chk("R9 set before disable", timeout_flag, 1'b1);
        enable = 1'b0; idle(3);
        chk("R9 flag kept while off", timeout_flag, 1'b1);
        chk("R10 irq kept while off", timeout_irq, 1'b1);
        enable = 1'b1;
        pulse_clr();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule